// File: doc/BRIEF.md
# Pointer-Addressed Display Controller Host Registers

This block is the host-facing register front end of a dot-matrix graphics display controller. The host reaches a small set of registers through an 8-bit data path. It uses a chip-select strobe and one register-select line. With register-select low, the host talks to a pointer register. With register-select high, the access goes to the register whose number the pointer holds. The registers behind the pointer are a port into display memory, an X and a Y address, a control register, a mode register and a column-select register.

A display-memory access becomes a request to an external RAM. The request carries the current X/Y address and is held until the RAM acknowledges. When the access completes, the block advances either X or Y. A busy flag covers three things: an access in progress, a short settling period after an X or Y address write, and a lockout window. The lockout window opens whenever the duty field or the frame-frequency divider field is changed. Its length in input clocks is derived from both fields. While busy is high, the display-memory port refuses accesses.

Top module: `lcd_host_regs`

## Requirements
- R1: While `cs_n` is high, writes change no register, `rdata_oe` is low and `rdata` is 0.
- R2: With `cs_n` low, `rs`=0 selects the pointer, whose bits 2:0 hold a register number. `rs`=1 selects the numbered register: 0 memory port, 1 X address, 2 Y address, 3 control, 4 mode, 5 column select.
- R3: A pointer read returns busy in bit 7, standby in bit 6, display-on in bit 5, zeros in bits 4:3 and the register number in bits 2:0.
- R4: Unused bits ignore writes and read 0. X uses bits 4:0 and Y uses bits 6:0. Control holds X-increment in bit 7, narrow-word in bit 6, display-on in bit 5, standby in bit 4 and duty in bits 1:0. Mode holds the divider select in bits 2:0. Column select uses bits 4:0.
- R5: Register numbers 6 and 7 read 0, and writes to them change no state.
- R6: A memory-port write raises `mem_req`/`mem_we` with the X/Y address and data on the next cycle. A memory-port read launches a fetch into a read buffer, and a later port read returns that buffer. Busy stays high from the cycle after the access through the acknowledge cycle.
- R7: With narrow-word set, bits 7:6 are forced to 0 in written data and in fetched data.
- R8: Each completed memory access increments X (wrapping) when X-increment is set, and otherwise increments Y.
- R9: An X or Y address write holds busy for 2 cycles. Control, mode, column and pointer writes add no busy time.
- R10: Changing the duty or divider field raises busy for ceil(D2/Ni) cycles, computed from the new settings. Duty 0→D2=192, 1→128, 2 and 3→96. Divider 0→Ni=2, 1→1, 2→1/2, 3→1/3, 4→1/4, 5→1/6, 6 and 7→1/8. Rewriting a field with its current value starts no lockout.
- R11: A memory-port access made while busy is dropped: no request is issued and the addresses stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rs | input | 1 | Register select: 0 pointer, 1 pointed register |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not driven |
| rdata_oe | output | 1 | Read data valid / drive enable |
| busy | output | 1 | Internal access or lockout in progress |
| mem_req | output | 1 | Display RAM request, held until acknowledge |
| mem_we | output | 1 | Request is a write |
| mem_x | output | 5 | Display RAM X address |
| mem_y | output | 7 | Display RAM Y address |
| mem_wdata | output | 8 | Display RAM write data |
| mem_rdata | input | 8 | Display RAM read data |
| mem_ack | input | 1 | Display RAM acknowledge |

## Verification
The bench measures the lockout length for every divider code and every D2 class, and each measurement must be exact. An off-by-one counter, a missed rounding step or a swapped divider entry therefore shows up as a wrong cycle count. A rewrite with an unchanged value must produce no lockout, so a design that reloads on every write is caught. Memory accesses issued during a lockout must leave the address registers untouched. The prefetching read buffer is checked by reading it back one access late. Narrow-word masking is checked on both the write and the read path. Invalid register numbers, unused bits and writes with the chip deselected are read back through the pointer and data path, so a design that leaks these writes into real state fails.

// File: rtl/lhr_pkg.sv
package lhr_pkg;

   typedef enum logic [2:0] {
      SEL_MEM  = 3'd0,
      SEL_X    = 3'd1,
      SEL_Y    = 3'd2,
      SEL_CTRL = 3'd3,
      SEL_MODE = 3'd4,
      SEL_COL  = 3'd5,
      SEL_NA6  = 3'd6,
      SEL_NA7  = 3'd7
   } sel_e;

   typedef struct packed {
      logic       inc_x;
      logic       narrow;
      logic       disp_on;
      logic       standby;
      logic [1:0] duty;
   } ctrl_t;

   // largest base weight times largest multiplier (1/8 divider)
   localparam int unsigned WORST_SETTLE_BASE = 192 * 8;

   function automatic int unsigned duty_weight(input logic [1:0] duty);
      case (duty)
         2'd0:    return 192;
         2'd1:    return 128;
         default: return 96;
      endcase
   endfunction

   function automatic int unsigned settle_cycles(input logic [1:0] duty,
                                                 input logic [2:0] fsel,
                                                 input int unsigned scale);
      int unsigned num;
      num = duty_weight(duty) * scale;
      case (fsel)
         3'd0:    return (num + 1) / 2;
         3'd1:    return num;
         3'd2:    return num * 2;
         3'd3:    return num * 3;
         3'd4:    return num * 4;
         3'd5:    return num * 6;
         default: return num * 8;
      endcase
   endfunction

endpackage

// File: rtl/lhr_lock_timer.sv
module lhr_lock_timer #(
   parameter int CW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          active
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign active = (cnt != '0);

   assert_lock_countdown_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !load) |=> (cnt == $past(cnt) - 1'b1));

   assert_lock_loaded_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/lhr_reg_file.sv
module lhr_reg_file
   import lhr_pkg::*;
#(
   parameter int XW             = 5,
   parameter int YW             = 7,
   parameter int COLW           = 5,
   parameter int XY_BUSY_CYCLES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ptr_we,
   input  logic            x_we,
   input  logic            y_we,
   input  logic            ctrl_we,
   input  logic            mode_we,
   input  logic            col_we,
   input  logic [7:0]      wdata,
   input  logic            step,
   output logic [2:0]      ptr_q,
   output logic [XW-1:0]   x_q,
   output logic [YW-1:0]   y_q,
   output ctrl_t           ctrl_q,
   output logic [2:0]      fsel_q,
   output logic [COLW-1:0] col_q,
   output logic            xy_busy
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         ctrl_q <= '0;
         fsel_q <= '0;
         col_q  <= '0;
      end else begin
         if (ptr_we)  ptr_q  <= wdata[2:0];
         if (ctrl_we) ctrl_q <= ctrl_t'({wdata[7:4], wdata[1:0]});
         if (mode_we) fsel_q <= wdata[2:0];
         if (col_we)  col_q  <= wdata[COLW-1:0];
      end
   end

   // host write wins over the auto-increment in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q <= '0;
         y_q <= '0;
      end else begin
         if (x_we)
            x_q <= wdata[XW-1:0];
         else if (step && ctrl_q.inc_x)
            x_q <= x_q + 1'b1;

         if (y_we)
            y_q <= wdata[YW-1:0];
         else if (step && !ctrl_q.inc_x)
            y_q <= y_q + 1'b1;
      end
   end

   generate
      if (XY_BUSY_CYCLES == 0) begin : g_no_xy_busy
         assign xy_busy = 1'b0;
      end else begin : g_xy_busy
         localparam int BW = $clog2(XY_BUSY_CYCLES + 1);
         logic [BW-1:0] xy_cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               xy_cnt <= '0;
            else if (x_we || y_we)
               xy_cnt <= BW'(XY_BUSY_CYCLES);
            else if (xy_cnt != '0)
               xy_cnt <= xy_cnt - 1'b1;
         end

         assign xy_busy = (xy_cnt != '0);

         assert_xy_busy_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (x_we || y_we) |=> (xy_cnt == BW'(XY_BUSY_CYCLES)));
      end
   endgenerate

   assert_y_held_on_xinc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (step && ctrl_q.inc_x && !y_we) |=> $stable(y_q));

endmodule

// File: rtl/lhr_mem_port.sv
module lhr_mem_port #(
   parameter int XW = 5,
   parameter int YW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          start_we,
   input  logic          narrow,
   input  logic [XW-1:0] x_in,
   input  logic [YW-1:0] y_in,
   input  logic [7:0]    wdata_in,
   input  logic          mem_ack,
   input  logic [7:0]    mem_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [XW-1:0] mem_x,
   output logic [YW-1:0] mem_y,
   output logic [7:0]    mem_wdata,
   output logic [7:0]    rbuf,
   output logic          done
);

   logic narrow_q;
   logic [7:0] in_mask, cap_mask;

   assign in_mask  = narrow   ? 8'h3F : 8'hFF;
   assign cap_mask = narrow_q ? 8'h3F : 8'hFF;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_req   <= 1'b0;
         mem_we    <= 1'b0;
         mem_x     <= '0;
         mem_y     <= '0;
         mem_wdata <= '0;
         narrow_q  <= 1'b0;
         rbuf      <= '0;
      end else if (start && !mem_req) begin
         mem_req   <= 1'b1;
         mem_we    <= start_we;
         mem_x     <= x_in;
         mem_y     <= y_in;
         mem_wdata <= wdata_in & in_mask;
         narrow_q  <= narrow;
      end else if (mem_req && mem_ack) begin
         mem_req <= 1'b0;
         if (!mem_we)
            rbuf <= mem_rdata & cap_mask;
      end
   end

   assign done = mem_req && mem_ack;

   assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_x) && $stable(mem_y) && $stable(mem_we)));

   assert_rbuf_narrow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !mem_we && narrow_q) |=> (rbuf[7:6] == 2'b00));

endmodule

// File: rtl/lcd_host_regs.sv
module lcd_host_regs
   import lhr_pkg::*;
#(
   parameter int XW             = 5,
   parameter int YW             = 7,
   parameter int COLW           = 5,
   parameter int XY_BUSY_CYCLES = 2,
   parameter int LOCK_SCALE     = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          rs,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata,
   output logic          rdata_oe,
   output logic          busy,
   output logic          mem_req,
   output logic          mem_we,
   output logic [XW-1:0] mem_x,
   output logic [YW-1:0] mem_y,
   output logic [7:0]    mem_wdata,
   input  logic [7:0]    mem_rdata,
   input  logic          mem_ack
);

   localparam int unsigned LOCK_MAX = WORST_SETTLE_BASE * LOCK_SCALE;
   localparam int          LOCK_W   = $clog2(LOCK_MAX + 1);

   generate
      if (XW < 1 || XW > 8) begin : g_bad_xw
         $error("XW must lie in 1..8");
      end
      if (YW < 1 || YW > 8) begin : g_bad_yw
         $error("YW must lie in 1..8");
      end
      if (COLW < 1 || COLW > 8) begin : g_bad_colw
         $error("COLW must lie in 1..8");
      end
      if (LOCK_SCALE < 1) begin : g_bad_scale
         $error("LOCK_SCALE must be at least 1");
      end
   endgenerate

   logic            acc_wr, acc_rd, acc_any;
   sel_e            sel;
   logic            ptr_we, x_we, y_we, ctrl_we, mode_we, col_we;
   logic [2:0]      ptr_q, fsel_q;
   logic [XW-1:0]   x_q;
   logic [YW-1:0]   y_q;
   ctrl_t           ctrl_q;
   logic [COLW-1:0] col_q;
   logic            xy_busy, lock_busy, mem_busy, mem_done, mem_go;
   logic [7:0]      rbuf, rd_mux;
   logic            lock_load;
   logic [1:0]      next_duty;
   logic [2:0]      next_fsel;
   logic [LOCK_W-1:0] lock_val;

   assign acc_wr  = !cs_n && wr_en;
   assign acc_rd  = !cs_n && rd_en;
   assign acc_any = acc_wr || acc_rd;
   assign sel     = sel_e'(ptr_q);

   assign ptr_we  = acc_wr && !rs;
   assign x_we    = acc_wr && rs && (sel == SEL_X);
   assign y_we    = acc_wr && rs && (sel == SEL_Y);
   assign ctrl_we = acc_wr && rs && (sel == SEL_CTRL);
   assign mode_we = acc_wr && rs && (sel == SEL_MODE);
   assign col_we  = acc_wr && rs && (sel == SEL_COL);

   assign mem_busy = mem_req;
   assign busy     = mem_busy || xy_busy || lock_busy;
   assign mem_go   = acc_any && rs && (sel == SEL_MEM) && !busy;

   // lockout reloads only on a real change of duty or divider
   assign next_duty = ctrl_we ? wdata[1:0] : ctrl_q.duty;
   assign next_fsel = mode_we ? wdata[2:0] : fsel_q;
   assign lock_load = (ctrl_we && (wdata[1:0] != ctrl_q.duty)) ||
                      (mode_we && (wdata[2:0] != fsel_q));
   assign lock_val  = LOCK_W'(settle_cycles(next_duty, next_fsel, LOCK_SCALE));

   lhr_reg_file #(
      .XW             (XW),
      .YW             (YW),
      .COLW           (COLW),
      .XY_BUSY_CYCLES (XY_BUSY_CYCLES)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .ptr_we  (ptr_we),
      .x_we    (x_we),
      .y_we    (y_we),
      .ctrl_we (ctrl_we),
      .mode_we (mode_we),
      .col_we  (col_we),
      .wdata   (wdata),
      .step    (mem_done),
      .ptr_q   (ptr_q),
      .x_q     (x_q),
      .y_q     (y_q),
      .ctrl_q  (ctrl_q),
      .fsel_q  (fsel_q),
      .col_q   (col_q),
      .xy_busy (xy_busy)
   );

   lhr_lock_timer #(
      .CW (LOCK_W)
   ) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (lock_load),
      .load_val (lock_val),
      .active   (lock_busy)
   );

   lhr_mem_port #(
      .XW (XW),
      .YW (YW)
   ) u_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (mem_go),
      .start_we  (wr_en),
      .narrow    (ctrl_q.narrow),
      .x_in      (x_q),
      .y_in      (y_q),
      .wdata_in  (wdata),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_x     (mem_x),
      .mem_y     (mem_y),
      .mem_wdata (mem_wdata),
      .rbuf      (rbuf),
      .done      (mem_done)
   );

   always_comb begin
      rd_mux = '0;
      if (!rs) begin
         rd_mux = {busy, ctrl_q.standby, ctrl_q.disp_on, 2'b00, ptr_q};
      end else begin
         case (sel)
            SEL_MEM:  rd_mux = rbuf;
            SEL_X:    rd_mux = 8'(x_q);
            SEL_Y:    rd_mux = 8'(y_q);
            SEL_CTRL: rd_mux = {ctrl_q.inc_x, ctrl_q.narrow, ctrl_q.disp_on,
                                ctrl_q.standby, 2'b00, ctrl_q.duty};
            SEL_MODE: rd_mux = {5'b00000, fsel_q};
            SEL_COL:  rd_mux = 8'(col_q);
            default:  rd_mux = '0;
         endcase
      end
   end

   assign rdata_oe = acc_rd;
   assign rdata    = rdata_oe ? rd_mux : 8'h00;

   assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (!rdata_oe && (rdata == 8'h00)));

   assert_deselect_no_ptr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> $stable(ptr_q));

   assert_status_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_oe && !rs) |-> (rdata[7] == busy && rdata[4:3] == 2'b00));

   assert_invalid_no_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && rs && ptr_q[2:1] == 2'b11 && !mem_req) |=>
         ($stable(x_q) && $stable(y_q) && $stable(ctrl_q) && $stable(fsel_q) && $stable(col_q)));

   assert_narrow_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_req) && mem_we && $past(ctrl_q.narrow)) |-> (mem_wdata[7:6] == 2'b00));

   assert_x_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_done && ctrl_q.inc_x && !x_we) |=> (x_q == XW'($past(x_q) + 1'b1)));

   assert_no_start_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> $past(!busy));

endmodule

// File: tb/lcd_host_regs_bench.sv
`timescale 1ns/1ps
module lcd_host_regs_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       rs = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       rdata_oe;
   logic       busy;
   logic       mem_req, mem_we, mem_ack;
   logic [4:0] mem_x;
   logic [6:0] mem_y;
   logic [7:0] mem_wdata, mem_rdata;

   int n_checks = 0;
   int n_errors = 0;

   always #2 clk = ~clk;

   lcd_host_regs u_lcd_host_regs (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rs(rs), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_x(mem_x), .mem_y(mem_y),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   // external RAM model: acknowledges two cycles after the request appears
   logic [7:0] ram [0:4095];
   logic [1:0] ack_cnt;
   assign mem_ack   = mem_req && (ack_cnt == 2'd2);
   assign mem_rdata = ram[{mem_y, mem_x}];

   always @(posedge clk) begin
      if (!rst_n)
         ack_cnt <= 2'd0;
      else if (mem_req && !mem_ack)
         ack_cnt <= ack_cnt + 2'd1;
      else
         ack_cnt <= 2'd0;
      if (mem_req && mem_ack && mem_we)
         ram[{mem_y, mem_x}] <= mem_wdata;
   end

   typedef struct packed {
      logic [2:0]  regn;
      logic [7:0]  data;
      logic [7:0]  rb;
      logic [15:0] lock;
   } vec_t;

   localparam vec_t VECS [0:10] = '{
      '{3'd4, 8'h01, 8'h01, 16'd192},
      '{3'd4, 8'h06, 8'h06, 16'd1536},
      '{3'd3, 8'h01, 8'h01, 16'd1024},
      '{3'd4, 8'h00, 8'h00, 16'd64},
      '{3'd3, 8'h02, 8'h02, 16'd48},
      '{3'd4, 8'h03, 8'h03, 16'd288},
      '{3'd4, 8'h05, 8'h05, 16'd576},
      '{3'd3, 8'h03, 8'h03, 16'd576},
      '{3'd4, 8'h04, 8'h04, 16'd384},
      '{3'd4, 8'h04, 8'h04, 16'd0},
      '{3'd3, 8'h33, 8'h33, 16'd0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel_rs, input logic [7:0] d);
      cs_n = 1'b0; rs = sel_rs; wr_en = 1'b1; wdata = d;
      @(negedge clk);
      cs_n = 1'b1; wr_en = 1'b0;
   endtask

   task automatic rd(input logic sel_rs, output logic [7:0] d);
      cs_n = 1'b0; rs = sel_rs; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      cs_n = 1'b1; rd_en = 1'b0;
   endtask

   task automatic set_reg(input logic [2:0] n, input logic [7:0] d);
      wr(1'b0, {5'b0, n});
      wr(1'b1, d);
   endtask

   task automatic get_reg(input logic [2:0] n, output logic [7:0] d);
      wr(1'b0, {5'b0, n});
      rd(1'b1, d);
   endtask

   task automatic busy_len(output int n);
      n = 0;
      while (busy && n < 4000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic wait_idle();
      int n;
      busy_len(n);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin : main
      logic [7:0] d;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      check("R3 reset busy", busy, 0);
      check("R6 reset mem_req", mem_req, 0);
      rd(1'b0, d);
      check("R3 reset pointer status", d, 8'h00);

      // lockout length table, each row followed by readback (R2, R4, R10)
      for (int i = 0; i < 11; i++) begin
         set_reg(VECS[i].regn, VECS[i].data);
         busy_len(n);
         check("R10 lockout length", n, VECS[i].lock);
         get_reg(VECS[i].regn, d);
         check("R2 readback of selected register", d, VECS[i].rb);
      end

      // R3: status with standby and display-on set, pointer at 3
      rd(1'b0, d);
      check("R3 pointer status", d, 8'h63);

      // R4 unused bits, R9 busy per register kind
      set_reg(3'd3, 8'hFF);
      busy_len(n);
      check("R9 control write no busy", n, 0);
      get_reg(3'd3, d);
      check("R4 control unused bits", d, 8'hF3);
      set_reg(3'd5, 8'hFF);
      busy_len(n);
      check("R9 column write no busy", n, 0);
      get_reg(3'd5, d);
      check("R4 column unused bits", d, 8'h1F);
      set_reg(3'd1, 8'hFF);
      busy_len(n);
      check("R9 X write busy", n, 2);
      get_reg(3'd1, d);
      check("R4 X unused bits", d, 8'h1F);
      set_reg(3'd2, 8'hFF);
      busy_len(n);
      check("R9 Y write busy", n, 2);
      get_reg(3'd2, d);
      check("R4 Y unused bits", d, 8'h7F);

      // R1: deselected accesses
      cs_n = 1'b1; rs = 1'b1; wr_en = 1'b1; wdata = 8'h11;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b1;
      #1;
      check("R1 rdata_oe deselected", rdata_oe, 0);
      check("R1 rdata deselected", rdata, 0);
      @(negedge clk);
      rd_en = 1'b0; rs = 1'b0; wr_en = 1'b1; wdata = 8'h05;
      @(negedge clk);
      wr_en = 1'b0;
      rd(1'b0, d);
      check("R1 pointer kept while deselected", d, 8'h62);
      rd(1'b1, d);
      check("R1 Y kept while deselected", d, 8'h7F);

      // R5: invalid register numbers
      set_reg(3'd3, 8'h03);
      wr(1'b0, 8'h06);
      wr(1'b1, 8'hAA);
      rd(1'b1, d);
      check("R5 register 6 reads 0", d, 8'h00);
      wr(1'b0, 8'h07);
      wr(1'b1, 8'h55);
      rd(1'b1, d);
      check("R5 register 7 reads 0", d, 8'h00);
      get_reg(3'd1, d);
      check("R5 X untouched", d, 8'h1F);
      get_reg(3'd3, d);
      check("R5 control untouched", d, 8'h03);
      get_reg(3'd5, d);
      check("R5 column untouched", d, 8'h1F);

      // R6 / R8: memory write with X increment
      set_reg(3'd1, 8'd3);
      wait_idle();
      set_reg(3'd2, 8'd10);
      wait_idle();
      set_reg(3'd3, 8'h83);
      wr(1'b0, 8'h00);
      wr(1'b1, 8'hA5);
      check("R6 request raised", {mem_req, mem_we}, 2'b11);
      check("R6 request address", {mem_y, mem_x}, {7'd10, 5'd3});
      check("R6 request data", mem_wdata, 8'hA5);
      busy_len(n);
      check("R6 busy through acknowledge", n, 3);
      check("R6 RAM written", ram[{7'd10, 5'd3}], 8'hA5);
      get_reg(3'd1, d);
      check("R8 X incremented", d, 8'd4);
      get_reg(3'd2, d);
      check("R8 Y held", d, 8'd10);

      // R8: Y increment
      set_reg(3'd3, 8'h03);
      wr(1'b0, 8'h00);
      wr(1'b1, 8'h5A);
      wait_idle();
      check("R8 RAM written at X=4", ram[{7'd10, 5'd4}], 8'h5A);
      get_reg(3'd2, d);
      check("R8 Y incremented", d, 8'd11);
      get_reg(3'd1, d);
      check("R8 X held", d, 8'd4);

      // R7: narrow word on write
      set_reg(3'd3, 8'h43);
      wr(1'b0, 8'h00);
      wr(1'b1, 8'hFF);
      check("R7 narrow write data", mem_wdata, 8'h3F);
      wait_idle();
      check("R7 RAM narrow value", ram[{7'd11, 5'd4}], 8'h3F);

      // R6: prefetching read buffer
      set_reg(3'd3, 8'h83);
      set_reg(3'd1, 8'd3);
      wait_idle();
      set_reg(3'd2, 8'd10);
      wait_idle();
      wr(1'b0, 8'h00);
      rd(1'b1, d);
      wait_idle();
      rd(1'b1, d);
      check("R6 prefetched read", d, 8'hA5);
      wait_idle();
      rd(1'b1, d);
      check("R6 second prefetched read", d, 8'h5A);
      wait_idle();

      // R7: narrow word on read
      set_reg(3'd3, 8'hC3);
      set_reg(3'd1, 8'd4);
      wait_idle();
      wr(1'b0, 8'h00);
      rd(1'b1, d);
      wait_idle();
      rd(1'b1, d);
      check("R7 narrow read data", d, 8'h1A);
      wait_idle();

      // R11: access refused during lockout (duty 3, divider 4 -> 0: 48 cycles)
      set_reg(3'd4, 8'h00);
      wr(1'b0, 8'h00);
      wr(1'b1, 8'h77);
      check("R11 no request during lockout", mem_req, 0);
      rd(1'b0, d);
      check("R3 busy bit during lockout", d, 8'h80);
      wait_idle();
      check("R11 no request after lockout", mem_req, 0);
      get_reg(3'd1, d);
      check("R11 X unchanged", d, 8'd6);
      get_reg(3'd2, d);
      check("R11 Y unchanged", d, 8'd10);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule